// File: doc/BRIEF.md
# Bus-Sharing Block Copy Engine

This block copies a run of words from one region of memory to another. It sits on a system bus that it shares with a processor. Software sets up the source address, the destination address and the word count. It then writes a control word that has a start bit set. The engine asks for the bus, waits for the arbiter to hand the bus over, and moves each word as a read from the source followed by a write to the destination. Every memory access is held until the memory acknowledges it by pulling an active-low ready line low.

The engine can keep the bus for the whole copy, or it can work in split mode. In split mode it gives the bus back after a programmable number of words and then asks for it again. This lets the processor use the bus between the pieces of a long copy. When the last word has been written, a done flag is set and, if enabled, an interrupt line is raised. While a copy runs, the register values stay fixed.

Top module: `dma_engine`

## Requirements
- R1: After reset the bus request, the access strobe and the interrupt are low, and the status word reads zero.
- R2: The register select codes are 0 source byte address, 1 destination byte address, 2 burst word count, 3 control and 4 status. In the control word, bits [LW-1:0] are the length in words, bit 29 enables the interrupt, bit 30 selects split mode and bit 31 is start. Start reads back as 0. In the status word, bit 0 is busy, bit 1 is done and bits [16+:LW] hold the remaining word count. All other registers read back as written.
- R3: A control write with start set while idle begins a copy. The engine raises bus_req, and it drives mem_strobe only while bus_gnt is high. If the grant is withheld, no access takes place.
- R4: Each word is a read (mem_rw=1) at the current source address, then a write (mem_rw=0) of that data at the current destination address. An access completes in the cycle where mem_rdy_n is low, and address and direction stay steady until then. Both addresses advance by WORD_BYTES per word, the remaining count falls by one, and memory outside the destination range is not written.
- R5: In continuous mode bus_req stays high from the first read to the last write, so there is one bus tenure per copy.
- R6: In split mode bus_req drops for at least one cycle after every burst-count words. The last burst may be shorter, and the number of tenures equals ceil(length/burst).
- R7: A burst count of zero in split mode acts as a burst count of one.
- R8: When the last write completes, done is set, busy clears and the remaining count reads 0. The irq output equals done AND interrupt enable. A new start clears done.
- R9: A start with length zero sets done without raising bus_req.
- R10: While busy, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Read data of the selected register |
| irq | output | 1 | Completion interrupt (done and enable) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_strobe | output | 1 | Memory access in progress |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when mem_rdy_n is low |
| mem_rdy_n | input | 1 | Active-low access acknowledge |

## Verification
The copy is run from a table of cases. These cover continuous mode and split mode, burst sizes that divide the length exactly and ones that leave a short last burst, a zero burst count, a single-word copy, and memory acknowledge latencies from zero to three cycles, with the grant delayed by the same amount. For each case the bench checks the destination data, the order of read and write addresses, the number of bus tenures and the word just past the destination. Together these show whether a fault lies in the data path, in address stepping, in burst release or in over-run. Directed cases then cover withheld grant, zero length, writes during a copy, and interrupt enable and clearing.

// File: rtl/dma_pkg.sv
// Shared definitions for the block copy engine: register select codes,
// control bit positions and the sequencer state type.
package dma_pkg;

    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_BURST = 3'd2;
    localparam logic [2:0] SEL_CTRL  = 3'd3;
    localparam logic [2:0] SEL_STAT  = 3'd4;

    localparam int CTRL_IRQEN = 29;
    localparam int CTRL_SPLIT = 30;
    localparam int CTRL_START = 31;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_DONE  = 1;
    localparam int STAT_REM   = 16;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_REQ,
        XS_RD,
        XS_WR,
        XS_GAP
    } xfer_state_e;

endpackage

// File: rtl/dma_regs.sv
// Register front end of the copy engine. Holds the programmed source,
// destination, burst count, length and mode bits. Turns a control write
// with the start bit into a one-cycle start pulse and keeps the done flag.
// Assumes AW <= DW, LW <= 16 and DW >= 32.
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          eng_busy,
    input  logic          done_evt,
    input  logic [LW-1:0] remaining,
    output logic [DW-1:0] cfg_rdata,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [LW-1:0] len_q,
    output logic [LW-1:0] burst_q,
    output logic          split_q,
    output logic          irqen_q,
    output logic          start_q,
    output logic          busy_o,
    output logic          done_q
);

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata[CTRL_IRQEN-1:LW];

    // A pending start pulse already counts as busy so no write slips in.
    assign busy_o = eng_busy | start_q;

    // Accept register writes only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            burst_q <= '0;
            split_q <= 1'b0;
            irqen_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (cfg_wr && !busy_o) begin
                case (cfg_sel)
                    SEL_SRC:   src_q   <= cfg_wdata[AW-1:0];
                    SEL_DST:   dst_q   <= cfg_wdata[AW-1:0];
                    SEL_BURST: burst_q <= cfg_wdata[LW-1:0];
                    SEL_CTRL: begin
                        len_q   <= cfg_wdata[LW-1:0];
                        irqen_q <= cfg_wdata[CTRL_IRQEN];
                        split_q <= cfg_wdata[CTRL_SPLIT];
                        start_q <= cfg_wdata[CTRL_START];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Done flag: set at completion, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (done_evt) done_q <= 1'b1;
        else if (start_q)  done_q <= 1'b0;
    end

    // Read-back multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_SRC:   cfg_rdata[AW-1:0] = src_q;
            SEL_DST:   cfg_rdata[AW-1:0] = dst_q;
            SEL_BURST: cfg_rdata[LW-1:0] = burst_q;
            SEL_CTRL: begin
                cfg_rdata[LW-1:0]       = len_q;
                cfg_rdata[CTRL_IRQEN]   = irqen_q;
                cfg_rdata[CTRL_SPLIT]   = split_q;
            end
            SEL_STAT: begin
                cfg_rdata[STAT_BUSY]       = busy_o;
                cfg_rdata[STAT_DONE]       = done_q;
                cfg_rdata[STAT_REM +: LW]  = remaining;
            end
            default: cfg_rdata = '0;
        endcase
    end

    // R10: a write while busy leaves every programmed value untouched.
    a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && busy_o) |=> ($stable(src_q) && $stable(dst_q) &&
                                $stable(len_q) && $stable(burst_q)));

    // R8: a start with no completion in the same cycle clears done.
    a_r8_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !done_evt) |=> !done_q);

endmodule

// File: rtl/dma_addr_gen.sv
// Working address and count registers. On load it takes the programmed
// source, destination and length. On each completed word it advances
// both addresses by one word and lowers the remaining count.
// Assumes step is never given while remaining is zero.
module dma_addr_gen #(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [LW-1:0] len_in,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [LW-1:0] remaining,
    output logic          last
);

    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

    // Load at start, step once per finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src   <= '0;
            cur_dst   <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_src   <= src_in;
            cur_dst   <= dst_in;
            remaining <= len_in;
        end else if (step) begin
            cur_src   <= cur_src + STRIDE;
            cur_dst   <= cur_dst + STRIDE;
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == LW'(1));

    // R4: each step lowers the count by exactly one.
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (remaining == $past(remaining) - LW'(1)));

    // R4: each step moves both addresses by one word.
    a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ((cur_src == $past(cur_src) + STRIDE) &&
                             (cur_dst == $past(cur_dst) + STRIDE)));

endmodule

// File: rtl/dma_xfer_fsm.sv
// Bus sequencer. Requests the bus, then alternates a read phase and a
// write phase per word. Each phase is held until the memory acknowledges.
// In split mode it drops the request for one cycle after each burst.
// Assumes the arbiter samples bus_req and drives bus_gnt.
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          len_zero,
    input  logic          split,
    input  logic [LW-1:0] burst,
    input  logic          last,
    input  logic          bus_gnt,
    input  logic          mem_rdy_n,
    output logic          bus_req,
    output logic          strobe,
    output logic          rd_phase,
    output logic          load,
    output logic          step,
    output logic          capture,
    output logic          done_evt,
    output logic          busy
);

    xfer_state_e   st, st_nxt;
    logic [LW-1:0] beat_cnt;
    logic          cnt_clr, cnt_inc;
    logic [LW:0]   burst_eff;
    logic          burst_end;
    logic          ack;

    // A zero burst count is treated as one word per burst.
    assign burst_eff = (burst == '0) ? (LW+1)'(1) : {1'b0, burst};
    assign burst_end = ({1'b0, beat_cnt} + (LW+1)'(1)) >= burst_eff;
    assign ack       = bus_gnt && !mem_rdy_n;

    // Next state and per-cycle controls.
    always_comb begin
        st_nxt   = st;
        load     = 1'b0;
        step     = 1'b0;
        capture  = 1'b0;
        done_evt = 1'b0;
        bus_req  = 1'b0;
        strobe   = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (st)
            XS_IDLE: begin
                if (start) begin
                    if (len_zero) begin
                        done_evt = 1'b1;
                    end else begin
                        load    = 1'b1;
                        cnt_clr = 1'b1;
                        st_nxt  = XS_REQ;
                    end
                end
            end
            XS_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) st_nxt = XS_RD;
            end
            XS_RD: begin
                bus_req = 1'b1;
                strobe  = bus_gnt;
                if (ack) begin
                    capture = 1'b1;
                    st_nxt  = XS_WR;
                end
            end
            XS_WR: begin
                bus_req = 1'b1;
                strobe  = bus_gnt;
                if (ack) begin
                    step = 1'b1;
                    if (last) begin
                        done_evt = 1'b1;
                        st_nxt   = XS_IDLE;
                    end else if (split && burst_end) begin
                        cnt_clr = 1'b1;
                        st_nxt  = XS_GAP;
                    end else begin
                        cnt_inc = 1'b1;
                        st_nxt  = XS_RD;
                    end
                end
            end
            XS_GAP:  st_nxt = XS_REQ;
            default: st_nxt = XS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= XS_IDLE;
        else        st <= st_nxt;
    end

    // Words completed in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_cnt <= '0;
        else if (cnt_clr) beat_cnt <= '0;
        else if (cnt_inc) beat_cnt <= beat_cnt + 1'b1;
    end

    assign rd_phase = (st == XS_RD);
    assign busy     = (st != XS_IDLE);

    // R5: outside split mode the request only falls once the copy ends.
    a_r5_hold_until_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_req) && !split) |-> (st == XS_IDLE));

    // R9: a zero-length start never raises the request.
    a_r9_zero_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XS_IDLE && start && len_zero) |=> !bus_req);

    // R6: the request stays low for a full cycle after each split burst.
    a_r6_gap_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XS_GAP) |-> (!bus_req && !strobe));

endmodule

// File: rtl/dma_engine.sv
// Top of the block copy engine. Joins the register front end, the address
// generator and the bus sequencer, holds the word in flight between its
// read and write, and drives the memory side of the shared bus.
// Assumes memory keeps mem_rdata valid in the cycle mem_rdy_n is low.
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_strobe,
    output logic          mem_rw,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rdy_n
);

    logic [AW-1:0] src_q, dst_q, cur_src, cur_dst;
    logic [LW-1:0] len_q, burst_q, remaining;
    logic          split_q, irqen_q, start_q, busy_o, done_q;
    logic          eng_busy, done_evt, load, step, capture, last, rd_phase;
    logic [DW-1:0] data_q;

    dma_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .eng_busy  (eng_busy),
        .done_evt  (done_evt),
        .remaining (remaining),
        .cfg_rdata (cfg_rdata),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .len_q     (len_q),
        .burst_q   (burst_q),
        .split_q   (split_q),
        .irqen_q   (irqen_q),
        .start_q   (start_q),
        .busy_o    (busy_o),
        .done_q    (done_q)
    );

    dma_addr_gen #(.AW(AW), .LW(LW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .src_in    (src_q),
        .dst_in    (dst_q),
        .len_in    (len_q),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .remaining (remaining),
        .last      (last)
    );

    dma_xfer_fsm #(.LW(LW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .len_zero  (len_q == '0),
        .split     (split_q),
        .burst     (burst_q),
        .last      (last),
        .bus_gnt   (bus_gnt),
        .mem_rdy_n (mem_rdy_n),
        .bus_req   (bus_req),
        .strobe    (mem_strobe),
        .rd_phase  (rd_phase),
        .load      (load),
        .step      (step),
        .capture   (capture),
        .done_evt  (done_evt),
        .busy      (eng_busy)
    );

    // Hold the word read from the source until its write completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= mem_rdata;
    end

    assign mem_rw    = rd_phase;
    assign mem_addr  = rd_phase ? cur_src : cur_dst;
    assign mem_wdata = data_q;
    assign irq       = done_q & irqen_q;

    // R3: an access only begins after the request was already out.
    a_r3_request_before_use: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_strobe) |-> (bus_req && $past(bus_req)));

    // R4: an unacknowledged access keeps its address and direction.
    a_r4_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && mem_rdy_n) |=> ($stable(mem_addr) && $stable(mem_rw)));

    // R8: done only rises with the remaining count at zero.
    a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (remaining == '0));

endmodule

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;

    localparam int AW = 32, DW = 32, LW = 16, WB = 4, MW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          irq, bus_req, mem_strobe, mem_rw;
    logic          bus_gnt = 1'b0;
    logic          mem_rdy_n = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #2 clk = ~clk;

    dma_engine #(.AW(AW), .DW(DW), .LW(LW), .WORD_BYTES(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_strobe(mem_strobe),
        .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy_n(mem_rdy_n)
    );

    // Table: src word, dst word, length, split, burst, latency
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{0, 32, 5, 0, 0, 0},
        '{2, 40, 7, 1, 3, 1},
        '{10, 20, 6, 1, 2, 0},
        '{4, 50, 4, 1, 4, 2},
        '{1, 30, 3, 1, 0, 0},
        '{0, 60, 1, 0, 0, 3}
    };

    logic [DW-1:0] mem [0:MW-1];
    int checks = 0, fails = 0;
    int lat = 0, gdelay = 0, gcnt = 0, wcnt = 0;
    int tenures = 0, nogrant = 0;
    logic prev_req = 1'b0;
    int run_id = 0, seen_id = 0, rd_n = 0, wr_n = 0, addr_err = 0;
    logic [AW-1:0] exp_src = '0, exp_dst = '0;

    function automatic logic [DW-1:0] pat(int i);
        return 32'h5A5A0000 ^ (i * 32'h01030507);
    endfunction

    function automatic logic [DW-1:0] ctrl(bit st, bit sp, bit ie, int len);
        logic [DW-1:0] w = '0;
        w[31] = st; w[30] = sp; w[29] = ie; w[LW-1:0] = LW'(len);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < MW; i++) mem[i] = pat(i);
    endtask

    // Memory and arbiter model, updated away from the active edge.
    always @(negedge clk) begin
        if (mem_strobe && !bus_gnt) nogrant++;
        if (mem_strobe && mem_rdy_n) begin
            if (wcnt >= lat) begin
                mem_rdy_n = 1'b0;
                wcnt = 0;
                if (mem_rw) mem_rdata = mem[(mem_addr >> 2) % MW];
            end else wcnt++;
        end else begin
            mem_rdy_n = 1'b1;
        end
        if (bus_req && !prev_req) tenures++;
        prev_req = bus_req;
        if (bus_req) begin
            if (gcnt >= gdelay) bus_gnt = 1'b1;
            else gcnt++;
        end else begin
            bus_gnt = 1'b0;
            gcnt = 0;
        end
    end

    // Completed accesses: memory write and address order checks.
    always @(posedge clk) begin
        if (seen_id != run_id) begin
            seen_id = run_id; rd_n = 0; wr_n = 0; addr_err = 0;
        end
        if (mem_strobe && !mem_rdy_n && bus_gnt) begin
            if (mem_rw) begin
                if (mem_addr !== exp_src + AW'(WB * rd_n)) addr_err++;
                rd_n++;
            end else begin
                if (mem_addr !== exp_dst + AW'(WB * wr_n)) addr_err++;
                mem[(mem_addr >> 2) % MW] = mem_wdata;
                wr_n++;
            end
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [DW-1:0] d);
        cfg_sel = sel;
        #0.1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] s;
        for (int k = 0; k < 8000; k++) begin
            cfg_read(3'd4, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic start_copy(int sw, int dw, int len, bit sp, int burst, bit ie);
        run_id++;
        tenures = 0;
        exp_src = AW'(sw * WB);
        exp_dst = AW'(dw * WB);
        cfg_write(3'd0, exp_src);
        cfg_write(3'd1, exp_dst);
        cfg_write(3'd2, DW'(burst));
        cfg_write(3'd3, ctrl(1'b1, sp, ie, len));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int bad, exp_ten;
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_read(3'd4, rd);
        chk("R1 status", rd, 32'h0);
        chk("R1 bus_req/strobe/irq", {29'b0, bus_req, mem_strobe, irq}, 32'h0);

        // R2: register read-back
        cfg_write(3'd0, 32'h0000_1234);
        cfg_write(3'd1, 32'h0000_5678);
        cfg_write(3'd2, 32'd7);
        cfg_write(3'd3, ctrl(1'b0, 1'b1, 1'b1, 9));
        cfg_read(3'd0, rd); chk("R2 src readback", rd, 32'h1234);
        cfg_read(3'd1, rd); chk("R2 dst readback", rd, 32'h5678);
        cfg_read(3'd2, rd); chk("R2 burst readback", rd, 32'd7);
        cfg_read(3'd3, rd); chk("R2 ctrl readback", rd, 32'h6000_0009);
        cfg_read(3'd4, rd); chk("R2 no start without bit31", rd, 32'h0);

        // Vector table: main copy function
        for (int v = 0; v < NV; v++) begin
            init_mem();
            lat = VEC[v][5];
            gdelay = VEC[v][5];
            nogrant = 0;
            start_copy(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3] != 0, VEC[v][4], 1'b0);
            wait_idle();
            bad = 0;
            for (int i = 0; i < VEC[v][2]; i++)
                if (mem[VEC[v][1] + i] !== pat(VEC[v][0] + i)) bad++;
            chk("R4 copied data", bad, 0);
            chk("R4 address order", addr_err, 0);
            chk("R4 word count", rd_n, VEC[v][2]);
            chk("R4 neighbour untouched", mem[VEC[v][1] + VEC[v][2]],
                pat(VEC[v][1] + VEC[v][2]));
            if (VEC[v][3] == 0) exp_ten = 1;
            else if (VEC[v][4] == 0) exp_ten = VEC[v][2];
            else exp_ten = (VEC[v][2] + VEC[v][4] - 1) / VEC[v][4];
            // R5 continuous, R6 split, R7 zero burst (vector 4)
            chk(VEC[v][3] == 0 ? "R5 tenures" : (VEC[v][4] == 0 ? "R7 tenures" : "R6 tenures"),
                tenures, exp_ten);
            cfg_read(3'd4, rd);
            chk("R8 final status", rd, 32'h2);
            chk("R3 strobe without grant", nogrant, 0);
        end

        // R3: withheld grant means no access
        init_mem();
        lat = 0; gdelay = 40;
        start_copy(0, 20, 2, 1'b0, 0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R3 request while waiting", {31'b0, bus_req}, 32'h1);
        chk("R3 no access without grant", {31'b0, mem_strobe}, 32'h0);
        wait_idle();
        chk("R3 data after late grant", mem[21], pat(1));
        gdelay = 0;

        // R9: zero length
        start_copy(0, 10, 0, 1'b0, 0, 1'b0);
        repeat (4) @(negedge clk);
        cfg_read(3'd4, rd);
        chk("R9 done without copy", rd, 32'h2);
        chk("R9 no bus request", tenures, 0);

        // R10: writes while busy ignored
        init_mem();
        lat = 3;
        start_copy(3, 40, 4, 1'b1, 2, 1'b0);
        cfg_write(3'd0, 32'h0000_0080);
        cfg_write(3'd1, 32'h0000_0084);
        cfg_write(3'd3, ctrl(1'b1, 1'b0, 1'b0, 9));
        wait_idle();
        cfg_read(3'd0, rd); chk("R10 src unchanged", rd, 32'd12);
        cfg_read(3'd1, rd); chk("R10 dst unchanged", rd, 32'd160);
        cfg_read(3'd3, rd); chk("R10 ctrl unchanged", rd, 32'h4000_0004);
        chk("R10 copy intact", mem[43], pat(6));
        chk("R10 tenures intact", tenures, 2);

        // R8: interrupt enable, and done clearing on start
        lat = 0;
        start_copy(0, 30, 2, 1'b0, 0, 1'b1);
        wait_idle();
        chk("R8 irq with enable", {31'b0, irq}, 32'h1);
        lat = 3;
        start_copy(0, 30, 3, 1'b0, 0, 1'b0);
        @(negedge clk);
        cfg_read(3'd4, rd);
        chk("R8 done cleared by start", rd[1:0], 32'h1);
        chk("R8 remaining loaded", rd[31:16], 32'd3);
        wait_idle();
        cfg_read(3'd4, rd);
        chk("R8 done after second copy", rd, 32'h2);
        chk("R8 irq without enable", {31'b0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule